// File: doc/BRIEF.md
# Subroutine Return Target Corrector

This block sits beside a taken-branch target table in an instruction prefetch unit. It corrects the predicted targets of subroutine returns. The table alone keeps one return target per return instruction. When a subroutine is called from more than one site, the stored target is the return point of whichever caller ran last, so it is often wrong. The block keeps two equal-depth stacks that are written together. One stack holds subroutine entry addresses (call targets). The other holds the matching return points, which are the sequential addresses after each call.

There are three event streams.

- **Call.** An executed call pushes a slot pair: the call target, and the call address plus the instruction length.
- **Return.** An executed return presents its actual target. The return-point stack is searched in parallel for that target. On a match, the table update for the return carries the paired entry address and a subroutine-return flag. On a miss, it carries the actual target with the flag clear.
- **Prefetch.** When a prefetch hits a table entry whose flag is set, the stored target (an entry address) is searched against the entry-address stack. The paired return point becomes the prediction. If the flag is clear, or nothing matches, the stored target passes through and the override indication stays low.

Each stream is a valid-qualified transfer. The block accepts every transfer in the cycle it is presented and applies no back-pressure. Each result appears on its own output with a valid strobe exactly one cycle later, and the consumer must take it in that cycle. A push that arrives while both stacks are full replaces the oldest slot pair. Returns never pop an entry.

Top module: `crs_predictor`

## Requirements
- R1: After reset every slot is invalid. A return lookup then misses, and a flagged prefetch lookup gives no override, until a call has been pushed.
- R2: A call pushes the pair (call target, call address + ILEN), where ILEN defaults to 4. A return to the call address itself does not match.
- R3: A return whose target equals a stored return point yields `upd_target` equal to the paired entry address and `upd_sub_ret` = 1.
- R4: A return whose target matches no valid return point yields `upd_target` equal to the return target and `upd_sub_ret` = 0.
- R5: A prefetch with `pf_sub_ret` = 1 whose target equals a stored entry address yields `pred_target` equal to the paired return point and `pred_override` = 1.
- R6: A prefetch with `pf_sub_ret` = 0 passes `pf_target` through with `pred_override` = 0, even when the target matches a stored entry.
- R7: A flagged prefetch whose target matches no valid entry address passes `pf_target` through with `pred_override` = 0.
- R8: When several slots match a lookup, the most recently pushed matching slot supplies the result.
- R9: With DEPTH slot pairs in use, a further push discards the oldest pair, and lookups for it then miss.
- R10: Lookups never change stored state. Repeating a lookup gives the same result.
- R11: A lookup presented in the same cycle as a call sees the stacks as they were before that call's push.
- R12: `upd_valid` is high exactly one cycle after `ret_valid`, and `pred_valid` exactly one cycle after `pf_valid`. Neither is high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_valid | input | 1 | An executed call is presented |
| call_pc | input | AW | Address of the call instruction |
| call_target | input | AW | Subroutine entry address |
| ret_valid | input | 1 | An executed return is presented |
| ret_target | input | AW | Actual target of the return |
| pf_valid | input | 1 | A prefetch table hit is presented |
| pf_sub_ret | input | 1 | Subroutine-return flag of the hit entry |
| pf_target | input | AW | Target stored in the hit entry |
| upd_valid | output | 1 | Table update for the return is valid |
| upd_target | output | AW | Target to write into the return's table entry |
| upd_sub_ret | output | 1 | Subroutine-return flag to write |
| pred_valid | output | 1 | Prediction is valid |
| pred_target | output | AW | Predicted prefetch target |
| pred_override | output | 1 | The prediction came from the stacks |

## Verification
The bench pushes one call more than the default depth of 5 and then looks up every pair it has ever pushed, through both lookups. A ring pointer that wraps wrongly would show up here as a wrong partner or as a stale hit on the evicted pair. Duplicate keys are pushed from different sites to test recency priority; a priority encoder by slot number instead of by age would return the older caller. Unflagged prefetches that hit a live entry are checked for pass-through, and a return aimed at the call address rather than the next instruction is checked for a miss; this catches a missing ILEN offset. A call and a lookup of its own return point are presented in the same cycle, which exposes a design that forwards a push into the same-cycle search.

// File: rtl/crs_pkg.sv
package crs_pkg;

  // Which of the paired stacks a search uses as its key side.
  typedef enum logic {
    KEY_ENTRY  = 1'b0,
    KEY_RETURN = 1'b1
  } crs_key_e;

  // Slot index of the pair pushed 'age' pushes before the newest one,
  // given the next-write pointer of a ring of 'depth' slots.
  function automatic int unsigned ring_index(input int unsigned wp,
                                             input int unsigned age,
                                             input int unsigned depth);
    int signed idx;
    idx = int'(wp) - 1 - int'(age);
    while (idx < 0) idx = idx + int'(depth);
    return int'(idx);
  endfunction

endpackage

// File: rtl/crs_slot_store.sv
module crs_slot_store #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned AW    = 32,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [AW-1:0]               push_entry,
  input  logic [AW-1:0]               push_ret,
  output logic [DEPTH-1:0][AW-1:0]    entry_q,
  output logic [DEPTH-1:0][AW-1:0]    ret_q,
  output logic [DEPTH-1:0]            vld_q,
  output logic [PW-1:0]               wp_q
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  // Ring pointer: the write slot always holds the oldest pair once full.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q <= '0;
    end else if (push) begin
      wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel;
    assign sel = push && (wp_q == PW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g]   <= 1'b0;
        entry_q[g] <= '0;
        ret_q[g]   <= '0;
      end else if (sel) begin
        vld_q[g]   <= 1'b1;
        entry_q[g] <= push_entry;
        ret_q[g]   <= push_ret;
      end
    end
  end

endmodule

// File: rtl/crs_match.sv
module crs_match
  import crs_pkg::*;
#(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned AW    = 32,
  parameter crs_key_e    KEY   = KEY_RETURN,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [AW-1:0]            key,
  input  logic [DEPTH-1:0][AW-1:0] entry_q,
  input  logic [DEPTH-1:0][AW-1:0] ret_q,
  input  logic [DEPTH-1:0]         vld_q,
  input  logic [PW-1:0]            wp_q,
  output logic                     hit,
  output logic [AW-1:0]            val
);

  logic [DEPTH-1:0][AW-1:0] keys;
  logic [DEPTH-1:0][AW-1:0] vals;
  logic [DEPTH-1:0]         eq;

  // The parameter picks which stack is searched and which one answers.
  if (KEY == KEY_RETURN) begin : g_key_ret
    assign keys = ret_q;
    assign vals = entry_q;
  end else begin : g_key_ent
    assign keys = entry_q;
    assign vals = ret_q;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = vld_q[g] && (keys[g] == key);
  end

  // Walk slots from newest to oldest; the first match wins.
  always_comb begin
    int unsigned idx;
    hit = 1'b0;
    val = '0;
    for (int unsigned age = 0; age < DEPTH; age++) begin
      idx = ring_index(int'(wp_q), age, DEPTH);
      if (!hit && eq[idx]) begin
        hit = 1'b1;
        val = vals[idx];
      end
    end
  end

endmodule

// File: rtl/crs_predictor.sv
module crs_predictor
  import crs_pkg::*;
#(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned AW    = 32,
  parameter int unsigned ILEN  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_valid,
  input  logic [AW-1:0] call_pc,
  input  logic [AW-1:0] call_target,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_target,
  input  logic          pf_valid,
  input  logic          pf_sub_ret,
  input  logic [AW-1:0] pf_target,
  output logic          upd_valid,
  output logic [AW-1:0] upd_target,
  output logic          upd_sub_ret,
  output logic          pred_valid,
  output logic [AW-1:0] pred_target,
  output logic          pred_override
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] STEP = AW'(ILEN);

  logic [DEPTH-1:0][AW-1:0] entry_q;
  logic [DEPTH-1:0][AW-1:0] ret_q;
  logic [DEPTH-1:0]         vld_q;
  logic [PW-1:0]            wp_q;
  logic [AW-1:0]            next_seq;

  logic          r_hit, p_hit;
  logic [AW-1:0] r_val, p_val;

  assign next_seq = call_pc + STEP;

  crs_slot_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (call_valid),
    .push_entry (call_target),
    .push_ret   (next_seq),
    .entry_q    (entry_q),
    .ret_q      (ret_q),
    .vld_q      (vld_q),
    .wp_q       (wp_q)
  );

  // Return side: search return points, answer with entry address.
  crs_match #(.DEPTH(DEPTH), .AW(AW), .KEY(KEY_RETURN)) ret_match_i (
    .key     (ret_target),
    .entry_q (entry_q),
    .ret_q   (ret_q),
    .vld_q   (vld_q),
    .wp_q    (wp_q),
    .hit     (r_hit),
    .val     (r_val)
  );

  // Prefetch side: search entry addresses, answer with return point.
  crs_match #(.DEPTH(DEPTH), .AW(AW), .KEY(KEY_ENTRY)) pf_match_i (
    .key     (pf_target),
    .entry_q (entry_q),
    .ret_q   (ret_q),
    .vld_q   (vld_q),
    .wp_q    (wp_q),
    .hit     (p_hit),
    .val     (p_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_valid   <= 1'b0;
      upd_target  <= '0;
      upd_sub_ret <= 1'b0;
    end else begin
      upd_valid <= ret_valid;
      if (ret_valid) begin
        upd_target  <= r_hit ? r_val : ret_target;
        upd_sub_ret <= r_hit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid    <= 1'b0;
      pred_target   <= '0;
      pred_override <= 1'b0;
    end else begin
      pred_valid <= pf_valid;
      if (pf_valid) begin
        pred_target   <= (pf_sub_ret && p_hit) ? p_val : pf_target;
        pred_override <= pf_sub_ret && p_hit;
      end
    end
  end

endmodule

// File: rtl/crs_predictor_chk.sv
module crs_predictor_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          call_valid,
  input logic          ret_valid,
  input logic [AW-1:0] ret_target,
  input logic          pf_valid,
  input logic          pf_sub_ret,
  input logic [AW-1:0] pf_target,
  input logic          upd_valid,
  input logic [AW-1:0] upd_target,
  input logic          upd_sub_ret,
  input logic          pred_valid,
  input logic [AW-1:0] pred_target,
  input logic          pred_override
);

  logic seen_call;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_call <= 1'b0;
    else if (call_valid) seen_call <= 1'b1;
  end

  AST_UPD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> upd_valid); // R12
  AST_UPD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> !upd_valid); // R12
  AST_PRED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |=> pred_valid); // R12
  AST_PRED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_valid |=> !pred_valid); // R12
  AST_EMPTY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !seen_call) |=> !upd_sub_ret); // R1
  AST_EMPTY_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !seen_call) |=> !pred_override); // R1
  AST_RET_MISS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> (upd_sub_ret || upd_target == $past(ret_target))); // R4
  AST_UNFLAGGED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_sub_ret) |=> (!pred_override && pred_target == $past(pf_target))); // R6
  AST_NO_OVR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |=> (pred_override || pred_target == $past(pf_target))); // R7

endmodule

bind crs_predictor crs_predictor_chk #(.AW(AW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .call_valid    (call_valid),
  .ret_valid     (ret_valid),
  .ret_target    (ret_target),
  .pf_valid      (pf_valid),
  .pf_sub_ret    (pf_sub_ret),
  .pf_target     (pf_target),
  .upd_valid     (upd_valid),
  .upd_target    (upd_target),
  .upd_sub_ret   (upd_sub_ret),
  .pred_valid    (pred_valid),
  .pred_target   (pred_target),
  .pred_override (pred_override)
);

// File: tb/crs_predictor_tb_top.sv
module crs_predictor_tb_top;

  localparam int unsigned DEPTH = 5;
  localparam int unsigned AW    = 32;
  localparam int unsigned ILEN  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          call_valid = 1'b0;
  logic [AW-1:0] call_pc = '0;
  logic [AW-1:0] call_target = '0;
  logic          ret_valid = 1'b0;
  logic [AW-1:0] ret_target = '0;
  logic          pf_valid = 1'b0;
  logic          pf_sub_ret = 1'b0;
  logic [AW-1:0] pf_target = '0;
  logic          upd_valid, upd_sub_ret, pred_valid, pred_override;
  logic [AW-1:0] upd_target, pred_target;

  int checks = 0;
  int errors = 0;

  // Bench reference: pairs kept oldest first, newest at mdl_n-1.
  logic [AW-1:0] mdl_ent [DEPTH];
  logic [AW-1:0] mdl_ret [DEPTH];
  int            mdl_n = 0;

  always #10 clk = ~clk;

  crs_predictor #(.DEPTH(DEPTH), .AW(AW), .ILEN(ILEN)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .call_valid(call_valid), .call_pc(call_pc), .call_target(call_target),
    .ret_valid(ret_valid), .ret_target(ret_target),
    .pf_valid(pf_valid), .pf_sub_ret(pf_sub_ret), .pf_target(pf_target),
    .upd_valid(upd_valid), .upd_target(upd_target), .upd_sub_ret(upd_sub_ret),
    .pred_valid(pred_valid), .pred_target(pred_target), .pred_override(pred_override)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic mdl_push(input logic [AW-1:0] ent, input logic [AW-1:0] rp);
    if (mdl_n == DEPTH) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        mdl_ent[i] = mdl_ent[i+1];
        mdl_ret[i] = mdl_ret[i+1];
      end
      mdl_n = DEPTH - 1;
    end
    mdl_ent[mdl_n] = ent;
    mdl_ret[mdl_n] = rp;
    mdl_n++;
  endtask

  // One cycle: drive at a falling edge, check at the next falling edge.
  task automatic step(input bit cv, input logic [AW-1:0] cpc, input logic [AW-1:0] ctg,
                      input bit rv, input logic [AW-1:0] rt,
                      input bit pv, input bit psr, input logic [AW-1:0] pt,
                      input string req);
    bit e_rhit = 0, e_phit = 0;
    logic [AW-1:0] e_rval = rt, e_pval = pt;
    for (int i = mdl_n - 1; i >= 0; i--) begin
      if (!e_rhit && mdl_ret[i] == rt) begin e_rhit = 1; e_rval = mdl_ent[i]; end
      if (!e_phit && psr && mdl_ent[i] == pt) begin e_phit = 1; e_pval = mdl_ret[i]; end
    end
    call_valid = cv; call_pc = cpc; call_target = ctg;
    ret_valid = rv; ret_target = rt;
    pf_valid = pv; pf_sub_ret = psr; pf_target = pt;
    @(negedge clk);
    call_valid = 0; ret_valid = 0; pf_valid = 0;
    if (rv) begin
      chk(upd_valid === 1'b1, req, "upd_valid", AW'(upd_valid), 1);
      chk(upd_target === e_rval, req, "upd_target", upd_target, e_rval);
      chk(upd_sub_ret === e_rhit, req, "upd_sub_ret", AW'(upd_sub_ret), AW'(e_rhit));
    end else begin
      chk(upd_valid === 1'b0, "R12", "idle upd_valid", AW'(upd_valid), 0);
    end
    if (pv) begin
      chk(pred_valid === 1'b1, req, "pred_valid", AW'(pred_valid), 1);
      chk(pred_target === e_pval, req, "pred_target", pred_target, e_pval);
      chk(pred_override === e_phit, req, "pred_override", AW'(pred_override), AW'(e_phit));
    end else begin
      chk(pred_valid === 1'b0, "R12", "idle pred_valid", AW'(pred_valid), 0);
    end
    if (cv) mdl_push(ctg, cpc + AW'(ILEN));
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    mdl_n = 0;
    chk(upd_valid === 1'b0 && pred_valid === 1'b0, "R1", "outputs after reset",
        AW'({upd_valid, pred_valid}), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [AW-1:0] pc, tg;
    do_reset();
    // R1: empty stacks give no match on either side.
    step(0, 0, 0, 1, 32'h1004, 1, 1, 32'h8000, "R1");
    // R12: idle cycle.
    step(0, 0, 0, 0, 0, 0, 0, 0, "R12");

    // R3 R5 R2: three distinct call sites, then lookups in both directions.
    for (int i = 0; i < 3; i++)
      step(1, 32'h1000 + i * 32'h100, 32'h8000 + i * 32'h40, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, 1, 32'h1004 + i * 32'h100, 1, 1, 32'h8000 + i * 32'h40, "R3/R5");
      step(0, 0, 0, 1, 32'h1000 + i * 32'h100, 0, 0, 0, "R2 no-offset miss");
    end
    // R10: repeat the same lookups, results unchanged.
    for (int r = 0; r < 2; r++)
      step(0, 0, 0, 1, 32'h1104, 1, 1, 32'h8040, "R10");
    // R6: unflagged prefetch that matches a live entry.
    step(0, 0, 0, 0, 0, 1, 0, 32'h8000, "R6");
    // R4 R7: misses on both sides.
    step(0, 0, 0, 1, 32'h7777, 1, 1, 32'h5555, "R4/R7");

    // R8: duplicate entry addresses and duplicate return points.
    do_reset();
    step(1, 32'h2000, 32'h9000, 0, 0, 0, 0, 0, "R8");
    step(1, 32'h3000, 32'h9000, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 1, 32'h9000, "R8 newest caller");
    step(1, 32'h4000, 32'hA000, 0, 0, 0, 0, 0, "R8");
    step(1, 32'h4000, 32'hB000, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 32'h4004, 0, 0, 0, "R8 newest entry");

    // R11: call and lookup of its own return point in one cycle, then after.
    do_reset();
    step(1, 32'h6000, 32'hC000, 1, 32'h6004, 1, 1, 32'hC000, "R11 same cycle");
    step(0, 0, 0, 1, 32'h6004, 1, 1, 32'hC000, "R11 next cycle");

    // R9: sweep fill levels 1..DEPTH+2, lookup every pair ever pushed.
    for (int n = 1; n <= DEPTH + 2; n++) begin
      do_reset();
      for (int k = 0; k < n; k++)
        step(1, 32'h10000 + k * 32'h10, 32'h20000 + k * 32'h20, 0, 0, 0, 0, 0, "R9");
      for (int k = 0; k < n; k++) begin
        pc = 32'h10000 + k * 32'h10;
        tg = 32'h20000 + k * 32'h20;
        step(0, 0, 0, 1, pc + ILEN, 1, 1, tg,
             (k < n - DEPTH) ? "R9 evicted" : "R9 retained");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule